// File: doc/BRIEF.md
# Line Interface Parallel Control Decoder

This block is the parallel control port of a telephone line interface. A host writes a three-bit mode code and two relay-request bits onto a shared bus and pulls an active-low input strobe. The block captures the word, decodes it into one of eight operating states and drives the two test-relay outputs straight from the captured relay bits.

Six digital supervision signals come in from analog detectors that sit outside this block: off-hook, ground-key, ring-trip, line fault, thermal alarm and power-cross. The operating state decides which detector feeds each of two active-low status flags. Fault and power-cross pull both flags low. Device reset and thermal alarm each force an idle state, and the two idle states differ in how they treat the relays and the flags.

The flags leave the core together with a pad output enable. The enable follows a second active-low strobe, so the pad drives the flags only while that strobe is low and is high-impedance otherwise. All ports are plain control and status pins. Nothing here carries a data stream, so there is no valid/ready handshake.

Top module: `line_ctrl_port`

## Requirements
- R1: The captured mode field `bus_mode` (value = {first, second, third} mode bit) selects a state. The state is reported one-hot on `state_onehot`, where bit index = code: 0 power-down, 1 stand-by, 2 active normal polarity, 3 active reverse polarity, 4 ringing normal, 5 ringing reverse, 6 ground start, 7 high-impedance feeding.
- R2: On a rising clock edge with `cs_in_n` low, the mode and relay bits are captured. While `cs_in_n` is high, the captured word holds.
- R3: `flags_oe` is 1 (pad drives the flags) exactly while `cs_out_n` is low, and 0 (high impedance) while it is high.
- R4: `hook_n` reports the inverted off-hook input in states 1, 2, 3, 6 and 7. It reports the inverted ring-trip input in states 4 and 5, and is disabled in state 0.
- R5: `gkey_n` reports the inverted ground-key input in states 1, 2, 3 and 6, and is disabled in states 0, 4, 5 and 7.
- R6: `relay_drv[i]` equals captured relay bit i (1 = relay energised) in every state, power-down included.
- R7: While `rst_n` is low, both relay outputs are 0, both flags are disabled, `state_onehot` shows power-down, and the captured word is cleared to zero.
- R8: A thermal alarm with reset inactive drives both flags low and shows power-down on `state_onehot`. The relay outputs still follow the captured relay bits.
- R9: A line fault or a power-cross drives both flags low for as long as it lasts. The captured mode and `state_onehot` do not change.
- R10: Reset takes priority over thermal alarm, fault and power-cross. Thermal alarm takes priority over the captured mode.
- R11: A disabled flag is driven to 1 (inactive), so it cannot be confused with an asserted flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| cs_in_n | input | 1 | Input strobe, active low; captures the bus word |
| cs_out_n | input | 1 | Output strobe, active low; enables the flag pads |
| bus_mode | input | 3 | Mode code from the shared bus |
| bus_relay | input | 2 | Relay-request bits from the shared bus, active high |
| det_offhook | input | 1 | Off-hook detector |
| det_gndkey | input | 1 | Ground-key detector |
| det_ringtrip | input | 1 | Ring-trip detector |
| det_fault | input | 1 | Line fault detector |
| det_thermal | input | 1 | Thermal alarm |
| det_pwrcross | input | 1 | Power-cross detector |
| relay_drv | output | 2 | Test-relay drive, active high |
| state_onehot | output | 8 | Decoded operating state, one-hot |
| hook_n | output | 1 | Hook / ring-trip flag, active low |
| gkey_n | output | 1 | Ground-key / alarm flag, active low |
| flags_oe | output | 1 | Pad output enable for both flags |

## Verification
Two things can happen in the same cycle, and the bench provokes both. The first is a new mode captured while a fault, power-cross or thermal condition is present. The second is reset overlapping the thermal alarm. Seeded random stimulus toggles the strobes, the bus and all six detectors independently, so these overlaps occur often. Directed cases pin them down: thermal and reset together, a fault in every mode, and a write while a fault is active. A bench model of the capture word and the priority order gives the expected result, and that result is compared with the state, the relay outputs and both flags a quarter period after each edge.

// File: rtl/line_ctrl_pkg.sv
package line_ctrl_pkg;
  localparam int MODE_W  = 3;
  localparam int N_STATE = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    ST_PWRDN   = 3'd0,
    ST_STBY    = 3'd1,
    ST_ACT_NP  = 3'd2,
    ST_ACT_RP  = 3'd3,
    ST_RING_NP = 3'd4,
    ST_RING_RP = 3'd5,
    ST_GSTART  = 3'd6,
    ST_HIZ     = 3'd7
  } op_state_e;

  // hook flag: 0 = disabled, 1 = off-hook source, 2 = ring-trip source
  function automatic logic [1:0] hook_src(input op_state_e s);
    case (s)
      ST_PWRDN:               hook_src = 2'd0;
      ST_RING_NP, ST_RING_RP: hook_src = 2'd2;
      default:                hook_src = 2'd1;
    endcase
  endfunction

  function automatic logic gkey_src(input op_state_e s);
    case (s)
      ST_STBY, ST_ACT_NP, ST_ACT_RP, ST_GSTART: gkey_src = 1'b1;
      default:                                  gkey_src = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/line_ctrl_capture.sv
module line_ctrl_capture #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (!strobe_n) q <= d;
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |=> (q == $past(d)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |=> $stable(q));
endmodule

// File: rtl/line_ctrl_decode.sv
module line_ctrl_decode
  import line_ctrl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MODE_W-1:0]     mode,
  input  logic                  idle,
  output logic [N_STATE-1:0]    state_onehot,
  output logic                  hook_en,
  output logic                  hook_use_rt,
  output logic                  gkey_en
);
  op_state_e eff;
  logic [1:0] hsel;

  assign eff = idle ? ST_PWRDN : op_state_e'(mode);

  for (genvar i = 0; i < N_STATE; i++) begin : g_onehot
    assign state_onehot[i] = (eff == op_state_e'(i));
  end

  always_comb begin
    hsel        = hook_src(eff);
    hook_en     = (hsel != 2'd0);
    hook_use_rt = (hsel == 2'd2);
    gkey_en     = gkey_src(eff);
  end

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_onehot) == 1);
  assert_idle_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (state_onehot[0] && !hook_en && !gkey_en));
endmodule

// File: rtl/line_ctrl_flag.sv
module line_ctrl_flag (
  input  logic in_reset,
  input  logic force_low,
  input  logic src_en,
  input  logic src_val,
  output logic flag_n
);
  always_comb begin
    if (in_reset)       flag_n = 1'b1;
    else if (force_low) flag_n = 1'b0;
    else if (src_en)    flag_n = ~src_val;
    else                flag_n = 1'b1;
  end
endmodule

// File: rtl/line_ctrl_port.sv
module line_ctrl_port
  import line_ctrl_pkg::*;
#(
  parameter int RELAY_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_in_n,
  input  logic                 cs_out_n,
  input  logic [MODE_W-1:0]    bus_mode,
  input  logic [RELAY_N-1:0]   bus_relay,
  input  logic                 det_offhook,
  input  logic                 det_gndkey,
  input  logic                 det_ringtrip,
  input  logic                 det_fault,
  input  logic                 det_thermal,
  input  logic                 det_pwrcross,
  output logic [RELAY_N-1:0]   relay_drv,
  output logic [N_STATE-1:0]   state_onehot,
  output logic                 hook_n,
  output logic                 gkey_n,
  output logic                 flags_oe
);
  localparam int WORD_W = MODE_W + RELAY_N;

  logic [WORD_W-1:0]  word_q;
  logic [MODE_W-1:0]  mode_q;
  logic [RELAY_N-1:0] relay_q;
  logic idle, force_low;
  logic hook_en, hook_use_rt, gkey_en;

  line_ctrl_capture #(.W(WORD_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (cs_in_n),
    .d        ({bus_mode, bus_relay}),
    .q        (word_q)
  );

  assign {mode_q, relay_q} = word_q;
  assign idle      = !rst_n || det_thermal;
  assign force_low = det_thermal || det_fault || det_pwrcross;

  line_ctrl_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode_q),
    .idle         (idle),
    .state_onehot (state_onehot),
    .hook_en      (hook_en),
    .hook_use_rt  (hook_use_rt),
    .gkey_en      (gkey_en)
  );

  line_ctrl_flag u_hook (
    .in_reset  (!rst_n),
    .force_low (force_low),
    .src_en    (hook_en),
    .src_val   (hook_use_rt ? det_ringtrip : det_offhook),
    .flag_n    (hook_n)
  );

  line_ctrl_flag u_gkey (
    .in_reset  (!rst_n),
    .force_low (force_low),
    .src_en    (gkey_en),
    .src_val   (det_gndkey),
    .flag_n    (gkey_n)
  );

  assign relay_drv = rst_n ? relay_q : '0;
  assign flags_oe  = !cs_out_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R7: assert (relay_drv == '0 && hook_n && gkey_n && state_onehot[0]);
    end
  end

  assert_thermal_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    det_thermal |-> (!hook_n && !gkey_n));
  assert_fault_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (det_fault || det_pwrcross) |-> (!hook_n && !gkey_n));
  assert_fault_keeps_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_in_n && !det_thermal && $past(!det_thermal) && $past(cs_in_n)) |-> $stable(state_onehot));
  assert_disabled_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_onehot[0] && !force_low) |-> (hook_n && gkey_n));
endmodule

// File: tb/line_ctrl_port_tb.sv
module line_ctrl_port_tb;
  localparam int PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_in_n = 1'b1, cs_out_n = 1'b1;
  logic [2:0] bus_mode = '0;
  logic [1:0] bus_relay = '0;
  logic d_oh = 0, d_gk = 0, d_rt = 0, d_flt = 0, d_th = 0, d_pc = 0;
  logic [1:0] relay_drv;
  logic [7:0] state_onehot;
  logic hook_n, gkey_n, flags_oe;

  int n_chk = 0, n_err = 0;
  logic [2:0] m_mode = '0;
  logic [1:0] m_relay = '0;

  always #(PER/2) clk = ~clk;

  line_ctrl_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_in_n(cs_in_n), .cs_out_n(cs_out_n),
    .bus_mode(bus_mode), .bus_relay(bus_relay),
    .det_offhook(d_oh), .det_gndkey(d_gk), .det_ringtrip(d_rt),
    .det_fault(d_flt), .det_thermal(d_th), .det_pwrcross(d_pc),
    .relay_drv(relay_drv), .state_onehot(state_onehot),
    .hook_n(hook_n), .gkey_n(gkey_n), .flags_oe(flags_oe)
  );

  function automatic logic [7:0] exp_state();
    return 8'd1 << ((!rst_n || d_th) ? 3'd0 : m_mode);
  endfunction

  function automatic logic exp_hook();
    if (!rst_n) return 1'b1;
    if (d_th || d_flt || d_pc) return 1'b0;
    case (m_mode)
      3'd0:       return 1'b1;
      3'd4, 3'd5: return ~d_rt;
      default:    return ~d_oh;
    endcase
  endfunction

  function automatic logic exp_gkey();
    if (!rst_n) return 1'b1;
    if (d_th || d_flt || d_pc) return 1'b0;
    case (m_mode)
      3'd1, 3'd2, 3'd3, 3'd6: return ~d_gk;
      default:                return 1'b1;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " state R1"}, state_onehot, exp_state());
    chk({tag, " relay R6"}, relay_drv, rst_n ? m_relay : 2'd0);
    chk({tag, " hook R4"}, hook_n, exp_hook());
    chk({tag, " gkey R5"}, gkey_n, exp_gkey());
    chk({tag, " oe R3"}, flags_oe, !cs_out_n);
  endtask

  // drive at negedge, model the capture at posedge, sample a quarter period later
  task automatic step(input logic r, input logic ci, input logic co,
                      input logic [2:0] bm, input logic [1:0] br, input logic [5:0] dv);
    @(negedge clk);
    rst_n = r; cs_in_n = ci; cs_out_n = co; bus_mode = bm; bus_relay = br;
    {d_oh, d_gk, d_rt, d_flt, d_th, d_pc} = dv;
    @(posedge clk);
    if (!r) begin m_mode = '0; m_relay = '0; end
    else if (!ci) begin m_mode = bm; m_relay = br; end
    #(PER/4);
  endtask

  initial begin
    #(PER * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // r7_ reset state: relays off, flags inactive, power-down
    step(0, 0, 0, 3'd2, 2'b11, 6'b110000);
    check_all("R7 reset");
    step(1, 1, 0, 3'd0, 2'b00, 6'b0);
    check_all("R7 after release");

    // R1/R4/R5/R11 sweep every mode with detectors on and off
    for (int m = 0; m < 8; m++) begin
      step(1, 0, 0, 3'(m), 2'(m), 6'b111000);
      check_all("R1 sweep active");
      step(1, 1, 0, 3'd0, 2'b00, 6'b000000);
      check_all("R11 sweep idle");
      chk("R2 hold", state_onehot, 8'd1 << m);
    end

    // R6 relay drive in power-down
    step(1, 0, 0, 3'd0, 2'b10, 6'b0);
    chk("R6 relay in power-down", relay_drv, 2'b10);

    // R3 output strobe high -> no pad drive
    step(1, 1, 1, 3'd0, 2'b00, 6'b0);
    chk("R3 oe off", flags_oe, 0);

    // R8 thermal keeps relays, flags low, power-down shown
    step(1, 0, 0, 3'd2, 2'b11, 6'b000000);
    step(1, 1, 0, 3'd0, 2'b00, 6'b000010);
    chk("R8 relay kept", relay_drv, 2'b11);
    chk("R8 hook low", hook_n, 0);
    chk("R8 gkey low", gkey_n, 0);
    chk("R8 state", state_onehot, 8'd1);
    step(1, 1, 0, 3'd0, 2'b00, 6'b000000);
    chk("R8 mode back", state_onehot, 8'd4);

    // R9 fault / power-cross in every mode, mode unchanged
    for (int m = 0; m < 8; m++) begin
      step(1, 0, 0, 3'(m), 2'b01, 6'b000100);
      chk("R9 fault hook", hook_n, 0);
      chk("R9 fault gkey", gkey_n, 0);
      chk("R9 fault state", state_onehot, 8'd1 << m);
      step(1, 1, 0, 3'd0, 2'b00, 6'b000001);
      chk("R9 pwrcross gkey", gkey_n, 0);
      chk("R9 pwrcross state", state_onehot, 8'd1 << m);
    end

    // R10 reset beats thermal and fault
    step(1, 0, 0, 3'd6, 2'b11, 6'b0);
    step(0, 1, 0, 3'd6, 2'b11, 6'b000111);
    chk("R10 reset flags", {hook_n, gkey_n}, 2'b11);
    chk("R10 reset relay", relay_drv, 0);
    check_all("R10 reset");
    step(1, 1, 0, 3'd6, 2'b11, 6'b000000);
    chk("R10 word cleared", state_onehot, 8'd1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[7:0] != 8'd0), r[8], r[9] & r[10], r[13:11], r[15:14],
           {r[16], r[17], r[18], r[21:19] == 3'd0, r[25:22] == 4'd0, r[28:26] == 3'd0});
      check_all("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule